// File: doc/BRIEF.md
# Stereo Master Volume Control Register

This block holds the master output volume setting for a stereo audio path. A 16-bit control word arrives on a simple write port. The block keeps a left and a right attenuation code, a master mute bit and a right-channel mute bit. From these it drives a 5-bit attenuation step and a mute flag for each channel to a downstream gain stage. One step is 1.5 dB, so the 32 levels run from 0 dB down to 46.5 dB of attenuation.

Each volume field is 6 bits wide, but only 5 bits reach the attenuator. A code that has its top bit set is clamped on write to the largest 5-bit step, and it reads back in that clamped form. A static split-mute input selects one of two mute schemes:
- Joined: the master mute silences both channels.
- Split: the master mute silences only the left channel, and a separate bit mutes the right channel.

A combinational readback port returns the stored word with the clamped and masked values.

Top module: `stereo_vol_reg`

## Requirements
- R1: Control word layout: bit 15 is the master mute, bits 13:8 are the left volume code, bits 5:0 are the right volume code, and bit 7 is the right mute. `rd_data` returns the stored word in this layout.
- R2: `left_atten` and `right_atten` equal the low five bits of the stored left and right codes. One step is 1.5 dB: 0 is 0 dB, 15 is 22.5 dB and 31 is 46.5 dB.
- R3: A written left (or right) code with bit 13 (or bit 5) set is stored as step 31. Readback then shows 01_1111 in that field, so bits 13 and 5 always read 0.
- R4: Bits 14 and 6 are never stored and always read 0.
- R5: With `split_mute` low, the master mute drives both `left_mute` and `right_mute`, and bit 7 reads 0.
- R6: A write made while `split_mute` is low stores the right-mute bit as 0, whatever value bit 7 of the written word has.
- R7: With `split_mute` high, the master mute drives only `left_mute`, and the stored bit 7 drives `right_mute` and reads back.
- R8: If `split_mute` falls while the stored bit 7 is 1, `right_mute` follows the master mute and bit 7 reads 0. If `split_mute` rises again with no write in between, the stored bit 7 takes effect again.
- R9: After reset the word reads 0x8000, both mute outputs are 1, and both attenuation outputs are 0.
- R10: The outputs are registered. They take the new value on the clock edge that accepts a write (`wr_en` high), so they are visible in the following cycle. With `wr_en` low, the attenuation outputs and `left_mute` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; `wr_data` is captured on the rising edge |
| wr_data | input | 16 | Control word to write |
| split_mute | input | 1 | 1 = separate left/right mutes, 0 = master mute drives both channels |
| rd_data | output | 16 | Stored control word as read back |
| left_atten | output | 5 | Left attenuation step (1.5 dB each) |
| left_mute | output | 1 | Left channel mute |
| right_atten | output | 5 | Right attenuation step (1.5 dB each) |
| right_mute | output | 1 | Right channel mute |

## Verification
The assertions assume that `wr_data` and `split_mute` are valid at every rising edge and that `wr_en` is a clean one-cycle strobe. They also assume that `split_mute` is sampled by the same clock as the register, so the mute outputs follow its value one edge late. The bench changes every input only on the falling edge. It drives `wr_en` for a single cycle per write. It toggles `split_mute` between writes as well as together with them, which covers both the joined and split mute paths and the case where the mode changes while bit 7 is stored.

// File: rtl/svr_pkg.sv
package svr_pkg;
  localparam int CODE_W = 6;
  localparam int STEP_W = 5;
  localparam int WORD_W = 16;

  // clamp a wide volume code onto the attenuator step range
  function automatic logic [STEP_W-1:0] clamp_code(input logic [CODE_W-1:0] code);
    if (code[CODE_W-1]) return {STEP_W{1'b1}};
    return code[STEP_W-1:0];
  endfunction

  typedef struct packed {
    logic l_mute;
    logic r_mute;
  } mute_pair_t;
endpackage

// File: rtl/svr_chan_sat.sv
module svr_chan_sat #(
  parameter int CODE_W = svr_pkg::CODE_W,
  parameter int STEP_W = svr_pkg::STEP_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [STEP_W-1:0] step,
  output logic              sat_hit
);
  always_comb begin
    sat_hit = code[CODE_W-1];
    step    = svr_pkg::clamp_code(code);
  end
endmodule

// File: rtl/svr_mute_map.sv
module svr_mute_map (
  input  logic                    split,
  input  logic                    master,
  input  logic                    right_bit,
  output svr_pkg::mute_pair_t     mutes
);
  always_comb begin
    mutes.l_mute = master;
    mutes.r_mute = split ? right_bit : master;
  end
endmodule

// File: rtl/stereo_vol_reg.sv
module stereo_vol_reg #(
  parameter int WORD_W = svr_pkg::WORD_W,
  parameter int CODE_W = svr_pkg::CODE_W,
  parameter int STEP_W = svr_pkg::STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              split_mute,
  output logic [WORD_W-1:0] rd_data,
  output logic [STEP_W-1:0] left_atten,
  output logic              left_mute,
  output logic [STEP_W-1:0] right_atten,
  output logic              right_mute
);
  localparam int MUTE_BIT  = WORD_W - 1;
  localparam int RMUTE_BIT = WORD_W / 2 - 1;
  localparam int LEFT_LSB  = WORD_W / 2;
  localparam int RIGHT_LSB = 0;
  localparam int NCH       = 2;

  logic                             master_q, master_d;
  logic                             rbit_q, rbit_d;
  logic [NCH-1:0][STEP_W-1:0]       vol_q, vol_d, sat_step;
  logic [NCH-1:0]                   sat_hit;
  logic                             wr_rbit_dropped;
  svr_pkg::mute_pair_t              mute_d;

  // channel 0 = right, channel 1 = left
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int LSB = (g == 0) ? RIGHT_LSB : LEFT_LSB;
    svr_chan_sat #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_sat (
      .code    (wr_data[LSB +: CODE_W]),
      .step    (sat_step[g]),
      .sat_hit (sat_hit[g])
    );
    assign vol_d[g] = wr_en ? sat_step[g] : vol_q[g];
  end

  assign wr_rbit_dropped = wr_en & wr_data[RMUTE_BIT] & ~split_mute;
  assign master_d = wr_en ? wr_data[MUTE_BIT] : master_q;
  assign rbit_d   = wr_en ? (wr_data[RMUTE_BIT] & split_mute) : rbit_q;

  svr_mute_map u_mute (
    .split     (split_mute),
    .master    (master_d),
    .right_bit (rbit_d),
    .mutes     (mute_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_q    <= 1'b1;
      rbit_q      <= 1'b0;
      vol_q       <= '0;
      left_atten  <= '0;
      right_atten <= '0;
      left_mute   <= 1'b1;
      right_mute  <= 1'b1;
    end else begin
      master_q    <= master_d;
      rbit_q      <= rbit_d;
      vol_q       <= vol_d;
      left_atten  <= vol_d[1];
      right_atten <= vol_d[0];
      left_mute   <= mute_d.l_mute;
      right_mute  <= mute_d.r_mute;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[MUTE_BIT]                  = master_q;
    rd_data[RMUTE_BIT]                 = rbit_q & split_mute;
    rd_data[LEFT_LSB +: STEP_W]        = vol_q[1];
    rd_data[RIGHT_LSB +: STEP_W]       = vol_q[0];
  end
endmodule

// File: rtl/stereo_vol_reg_chk.sv
module stereo_vol_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        split_mute,
  input logic [15:0] rd_data,
  input logic [4:0]  left_atten,
  input logic        left_mute,
  input logic [4:0]  right_atten,
  input logic        right_mute
);
  // R3
  left_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[13]) |=> left_atten == 5'h1f);
  // R3
  right_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[5]) |=> right_atten == 5'h1f);
  // R4
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[14] == 1'b0 && rd_data[6] == 1'b0);
  // R5
  joined_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(split_mute) |-> right_mute == left_mute);
  // R5
  rbit_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !split_mute |-> rd_data[7] == 1'b0);
  // R2
  atten_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_atten == rd_data[12:8] && right_atten == rd_data[4:0]);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(left_atten) && $stable(right_atten) && $stable(left_mute));
endmodule

bind stereo_vol_reg stereo_vol_reg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .split_mute  (split_mute),
  .rd_data     (rd_data),
  .left_atten  (left_atten),
  .left_mute   (left_mute),
  .right_atten (right_atten),
  .right_mute  (right_mute)
);

// File: tb/stereo_vol_reg_test.sv
module stereo_vol_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        split_mute = 1'b0;
  logic [15:0] rd_data;
  logic [4:0]  left_atten, right_atten;
  logic        left_mute, right_mute;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  stereo_vol_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .split_mute(split_mute), .rd_data(rd_data),
    .left_atten(left_atten), .left_mute(left_mute),
    .right_atten(right_atten), .right_mute(right_mute)
  );

  localparam int NV = 9;
  localparam logic        V_SPLIT [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 0};
  localparam logic [15:0] V_WR    [NV] = '{16'h0000, 16'h8F0F, 16'h2020, 16'h3FBF,
                                           16'h0080, 16'h8000, 16'h4A55, 16'h25F3, 16'h0103};
  localparam logic [15:0] V_RD    [NV] = '{16'h0000, 16'h8F0F, 16'h1F1F, 16'h1F1F,
                                           16'h0080, 16'h8000, 16'h0A15, 16'h1F9F, 16'h0103};
  localparam logic [4:0]  V_LA    [NV] = '{0, 15, 31, 31, 0, 0, 10, 31, 1};
  localparam logic [4:0]  V_RA    [NV] = '{0, 15, 31, 31, 0, 0, 21, 31, 3};
  localparam logic        V_LM    [NV] = '{0, 1, 0, 0, 0, 1, 0, 0, 0};
  localparam logic        V_RM    [NV] = '{0, 1, 0, 0, 1, 0, 0, 1, 0};

  task automatic check_all(input string req, input logic [15:0] erd,
                           input logic [4:0] ela, input logic elm,
                           input logic [4:0] era, input logic erm);
    n_chk++;
    if (rd_data !== erd || left_atten !== ela || left_mute !== elm ||
        right_atten !== era || right_mute !== erm) begin
      n_fail++;
      $display("FAIL %s: got rd=%h la=%0d lm=%b ra=%0d rm=%b, expected rd=%h la=%0d lm=%b ra=%0d rm=%b",
               req, rd_data, left_atten, left_mute, right_atten, right_mute,
               erd, ela, elm, era, erm);
    end
  endtask

  task automatic do_write(input logic sp, input logic [15:0] d);
    @(negedge clk);
    split_mute = sp; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    check_all("R9 reset", 16'h8000, 0, 1'b1, 0, 1'b1);

    // R1 R2 R3 R4 R5 R6 R7: vector table
    for (int i = 0; i < NV; i++) begin
      do_write(V_SPLIT[i], V_WR[i]);
      check_all($sformatf("R1/R3 vector %0d", i), V_RD[i], V_LA[i], V_LM[i], V_RA[i], V_RM[i]);
    end

    // R10: outputs unchanged in the write cycle, new value after the edge
    @(negedge clk);
    split_mute = 1'b0; wr_data = 16'h8505; wr_en = 1'b1;
    #1 check_all("R10 before edge", 16'h0103, 1, 1'b0, 3, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    check_all("R10 after edge", 16'h8505, 5, 1'b1, 5, 1'b1);
    // R10: data changes without wr_en are ignored
    wr_data = 16'h0000;
    repeat (2) @(negedge clk);
    check_all("R10 no write", 16'h8505, 5, 1'b1, 5, 1'b1);

    // R8: split on, right muted via bit 7, then split off
    do_write(1'b1, 16'h0080);
    check_all("R7 right bit", 16'h0080, 0, 1'b0, 0, 1'b1);
    split_mute = 1'b0;
    #1 n_chk++;
    if (rd_data !== 16'h0000) begin
      n_fail++;
      $display("FAIL R8 readback: got %h expected 0000", rd_data);
    end
    @(negedge clk);
    check_all("R8 split off", 16'h0000, 0, 1'b0, 0, 1'b0);
    split_mute = 1'b1;
    @(negedge clk);
    check_all("R8 split back on", 16'h0080, 0, 1'b0, 0, 1'b1);

    // R6: bit 7 written while split low is dropped
    do_write(1'b0, 16'h0080);
    split_mute = 1'b1;
    @(negedge clk);
    check_all("R6 dropped bit7", 16'h0000, 0, 1'b0, 0, 1'b0);

    // R5: joined mute with master set
    do_write(1'b0, 16'h800F);
    check_all("R5 joined mute", 16'h800F, 0, 1'b1, 15, 1'b1);

    // R9: reset again restores default
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    split_mute = 1'b0;
    check_all("R9 re-reset", 16'h8000, 0, 1'b1, 0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule